// File: doc/BRIEF.md
# Cache Miss Queue and Bus Issuer

This block sits between an upper-level cache and the system bus. It keeps track of the line misses that are still outstanding. Instruction-side and data-side requesters each offer a missing line address. Accepted misses are held in a small table. They go out to the bus as pipelined read transactions, in the order they were accepted. A single writeback (castout) entry can be offered alongside the misses and goes out as a write transaction.

Every bus request carries a transaction ID. Miss entries use their table slot number as the ID, and the castout entry uses the number just past the last slot. The bus returns a completion naming an ID, and completions may come back in any order. A completion frees the matching entry.

The block limits the mix of outstanding misses: the table holds four, and at most one of them may be an instruction miss. Together with the castout this gives at most five bus transactions in flight. A miss to a line that is already outstanding is merged into the existing entry.

Top module: `miss_issue_queue`

## Requirements
- R1: After reset, `imiss_ready`, `dmiss_ready` and `co_ready` are high, and `bus_req_valid` is low.
- R2: The table holds DEPTH (4) outstanding misses. `dmiss_ready` is low while all entries are occupied.
- R3: `imiss_ready` is low while an instruction miss is outstanding, even if free entries remain.
- R4: A miss whose line address equals an outstanding entry's address is accepted but takes no entry. It produces no bus request.
- R5: Misses are requested on the bus in acceptance order, with `bus_req_cast` = 0 and `bus_req_id` equal to the slot number (0 to DEPTH-1). A slot is never reused while its ID is in flight.
- R6: The castout buffer holds one entry. It is requested with `bus_req_cast` = 1 and `bus_req_id` = DEPTH. `co_ready` stays low from acceptance until the completion with ID DEPTH.
- R7: A pending castout is requested before any miss still waiting to issue. The one exception is a miss request already being presented and not yet taken.
- R8: A completion frees the issued entry whose ID it names, in any order. A completion naming an entry that is free or not yet issued has no effect.
- R9: While `bus_req_valid` is high and `bus_req_ready` is low, the request address, ID and cast flag stay unchanged.
- R10: Both requesters may be accepted in the same cycle; the instruction miss takes the lower free slot and issues first. If only one slot is free and an instruction miss is allocated, `dmiss_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imiss_valid | input | 1 | Instruction miss offered |
| imiss_addr | input | AW | Instruction miss line address |
| imiss_ready | output | 1 | Instruction miss may be accepted |
| dmiss_valid | input | 1 | Data miss offered |
| dmiss_addr | input | AW | Data miss line address |
| dmiss_ready | output | 1 | Data miss may be accepted |
| co_valid | input | 1 | Castout offered |
| co_addr | input | AW | Castout line address |
| co_ready | output | 1 | Castout buffer empty |
| bus_req_valid | output | 1 | Bus request presented |
| bus_req_addr | output | AW | Bus request line address |
| bus_req_id | output | IDW | Bus request transaction ID |
| bus_req_cast | output | 1 | 1 = castout write, 0 = miss read |
| bus_req_ready | input | 1 | Bus takes the request this cycle |
| cpl_valid | input | 1 | Bus completion |
| cpl_id | input | IDW | ID of the completed transaction |

## Verification
The bench fills the table while the bus is stalled. It then checks two points:
- After an instruction miss, the instruction side closes with free slots left. A design that only tests for a full table would accept a second instruction miss.
- A repeated address must leave the data side open. A design that failed to merge would fill the table and drop `dmiss_ready`, and the scoreboard would also see an extra request.

A castout arrives while a stalled miss is being presented. The expected order is: that miss, then the castout, then the remaining misses. A design without the hold rule changes the presented request mid-stall. A design without castout priority sends the write last.

Three more cases are covered:
- A completion for a not-yet-issued slot must not free it.
- Out-of-order completions must reopen the instruction side and the castout buffer.
- Simultaneous instruction and data offers against one free slot must refuse the data side.

// File: rtl/miss_issue_queue.sv
module miss_issue_queue #(
  parameter int AW = 32,
  parameter int DEPTH = 4,
  localparam int IDW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           imiss_valid,
  input  logic [AW-1:0]  imiss_addr,
  output logic           imiss_ready,
  input  logic           dmiss_valid,
  input  logic [AW-1:0]  dmiss_addr,
  output logic           dmiss_ready,
  input  logic           co_valid,
  input  logic [AW-1:0]  co_addr,
  output logic           co_ready,
  output logic           bus_req_valid,
  output logic [AW-1:0]  bus_req_addr,
  output logic [IDW-1:0] bus_req_id,
  output logic           bus_req_cast,
  input  logic           bus_req_ready,
  input  logic           cpl_valid,
  input  logic [IDW-1:0] cpl_id
);
  typedef enum logic [1:0] {CO_EMPTY, CO_PEND, CO_FLY} co_t;

  logic [DEPTH-1:0] v, ins, iss;
  logic [AW-1:0]    a [DEPTH];
  logic [SW-1:0]    ord [DEPTH];
  logic [SW-1:0]    ord_n [DEPTH];
  logic [SW:0]      oc, oc_n, cnt;
  co_t              co_st;
  logic [AW-1:0]    co_a;
  logic             lock, lock_co;

  logic [SW-1:0] fs0, fs1, d_slot, head;
  logic f0, f1, imatch, dmatch;
  logic full, iout, i_alloc, d_alloc, sel_co, fire, pop;

  always_comb begin
    fs0 = '0; fs1 = '0; f0 = 1'b0; f1 = 1'b0;
    imatch = 1'b0; dmatch = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!v[i]) begin
        if (!f0) begin fs0 = SW'(i); f0 = 1'b1; end
        else if (!f1) begin fs1 = SW'(i); f1 = 1'b1; end
      end
      if (v[i] && a[i] == imiss_addr) imatch = 1'b1;
      if (v[i] && a[i] == dmiss_addr) dmatch = 1'b1;
    end
  end

  assign cnt  = (SW+1)'($countones(v));
  assign full = &v;
  assign iout = |(v & ins);

  assign imiss_ready = !full && !iout;
  assign i_alloc     = imiss_valid && imiss_ready && !imatch;
  assign dmiss_ready = !full && !(i_alloc && cnt == (SW+1)'(DEPTH - 1));
  assign d_alloc     = dmiss_valid && dmiss_ready && !dmatch &&
                       !(i_alloc && dmiss_addr == imiss_addr);
  assign d_slot      = i_alloc ? fs1 : fs0;

  assign co_ready      = co_st == CO_EMPTY;
  assign head          = ord[0];
  assign sel_co        = lock ? lock_co : (co_st == CO_PEND);
  assign bus_req_valid = sel_co || oc != '0;
  assign bus_req_cast  = sel_co;
  assign bus_req_addr  = sel_co ? co_a : a[head];
  assign bus_req_id    = sel_co ? IDW'(DEPTH) : IDW'(head);
  assign fire          = bus_req_valid && bus_req_ready;
  assign pop           = fire && !sel_co;

  always_comb begin
    ord_n = ord;
    oc_n  = oc;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) ord_n[i] = ord[i+1];
      oc_n = oc - 1'b1;
    end
    if (i_alloc) begin
      ord_n[oc_n[SW-1:0]] = fs0;
      oc_n = oc_n + 1'b1;
    end
    if (d_alloc) begin
      ord_n[oc_n[SW-1:0]] = d_slot;
      oc_n = oc_n + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v <= '0; ins <= '0; iss <= '0; oc <= '0;
      co_st <= CO_EMPTY; co_a <= '0; lock <= 1'b0; lock_co <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        a[i] <= '0;
        ord[i] <= '0;
      end
    end else begin
      ord <= ord_n;
      oc  <= oc_n;
      lock    <= bus_req_valid && !bus_req_ready;
      lock_co <= sel_co;
      for (int i = 0; i < DEPTH; i++) begin
        if (cpl_valid && cpl_id == IDW'(i) && v[i] && iss[i]) v[i] <= 1'b0;
        if (pop && head == SW'(i)) iss[i] <= 1'b1;
        if (i_alloc && fs0 == SW'(i)) begin
          v[i] <= 1'b1; ins[i] <= 1'b1; iss[i] <= 1'b0; a[i] <= imiss_addr;
        end
        if (d_alloc && d_slot == SW'(i)) begin
          v[i] <= 1'b1; ins[i] <= 1'b0; iss[i] <= 1'b0; a[i] <= dmiss_addr;
        end
      end
      case (co_st)
        CO_EMPTY: if (co_valid) begin co_st <= CO_PEND; co_a <= co_addr; end
        CO_PEND:  if (fire && sel_co) co_st <= CO_FLY;
        CO_FLY:   if (cpl_valid && cpl_id == IDW'(DEPTH)) co_st <= CO_EMPTY;
        default:  co_st <= CO_EMPTY;
      endcase
    end
  end
endmodule

// File: rtl/miss_issue_queue_chk.sv
module miss_issue_queue_chk #(
  parameter int AW = 32,
  parameter int DEPTH = 4,
  localparam int IDW = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           co_valid,
  input logic           co_ready,
  input logic           bus_req_valid,
  input logic [AW-1:0]  bus_req_addr,
  input logic [IDW-1:0] bus_req_id,
  input logic           bus_req_cast,
  input logic           bus_req_ready,
  input logic           cpl_valid,
  input logic [IDW-1:0] cpl_id
);
  logic [2**IDW-1:0] fly;
  logic fire;
  assign fire = bus_req_valid && bus_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) fly <= '0;
    else begin
      if (cpl_valid) fly[cpl_id] <= 1'b0;
      if (fire) fly[bus_req_id] <= 1'b1;
    end
  end

  a_r5_id_not_reused: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !fly[bus_req_id]);
  a_r5_miss_id_range: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !bus_req_cast) |-> (32'(bus_req_id) < DEPTH));
  a_r6_castout_id: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && bus_req_cast) |-> (32'(bus_req_id) == DEPTH));
  a_r6_castout_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (co_valid && co_ready) |=> !co_ready);
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=> (bus_req_valid && $stable(bus_req_addr)
      && $stable(bus_req_id) && $stable(bus_req_cast)));
endmodule

bind miss_issue_queue miss_issue_queue_chk #(.AW(AW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .co_valid(co_valid), .co_ready(co_ready),
  .bus_req_valid(bus_req_valid), .bus_req_addr(bus_req_addr),
  .bus_req_id(bus_req_id), .bus_req_cast(bus_req_cast),
  .bus_req_ready(bus_req_ready), .cpl_valid(cpl_valid), .cpl_id(cpl_id)
);

// File: tb/miss_issue_queue_tb_top.sv
module miss_issue_queue_tb_top;
  localparam int AW = 32;
  localparam int DEPTH = 4;
  localparam int IDW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic imiss_valid = 0, dmiss_valid = 0, co_valid = 0, bus_req_ready = 0, cpl_valid = 0;
  logic [AW-1:0] imiss_addr = '0, dmiss_addr = '0, co_addr = '0;
  logic [IDW-1:0] cpl_id = '0;
  logic imiss_ready, dmiss_ready, co_ready, bus_req_valid, bus_req_cast;
  logic [AW-1:0] bus_req_addr;
  logic [IDW-1:0] bus_req_id;

  int checks = 0, fails = 0, cycles = 0;
  logic [AW+IDW:0] exp_q[$];

  always #4 clk = ~clk;

  miss_issue_queue #(.AW(AW), .DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_req(logic [AW-1:0] ad, int id, logic cast);
    exp_q.push_back({cast, IDW'(id), ad});
  endtask

  // monitor: compare each bus request taken against the scoreboard
  always begin
    @(negedge clk); #2;
    if (rst_n && bus_req_valid && bus_req_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4/R5: unexpected request actual %0h expected none",
                 {bus_req_cast, bus_req_id, bus_req_addr});
      end else
        chk("R5/R7 bus order", {bus_req_cast, bus_req_id, bus_req_addr}, exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic dmiss(logic [AW-1:0] ad);
    dmiss_valid = 1; dmiss_addr = ad; @(negedge clk); dmiss_valid = 0;
  endtask
  task automatic imiss(logic [AW-1:0] ad);
    imiss_valid = 1; imiss_addr = ad; @(negedge clk); imiss_valid = 0;
  endtask
  task automatic cpl(int id);
    cpl_valid = 1; cpl_id = IDW'(id); @(negedge clk); cpl_valid = 0;
  endtask
  task automatic drain();
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); #3;
      if (exp_q.size() == 0) break;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 imiss_ready", imiss_ready, 1);
    chk("R1 dmiss_ready", dmiss_ready, 1);
    chk("R1 co_ready", co_ready, 1);
    chk("R1 bus_req_valid", bus_req_valid, 0);
    @(negedge clk);

    dmiss(32'h1000);
    dmiss(32'h1040);
    imiss(32'h2000);
    #1; chk("R3 imiss_ready low with one instr outstanding", imiss_ready, 0);
    dmiss(32'h1040);
    #1; chk("R4 merge keeps a slot free", dmiss_ready, 1);
    dmiss(32'h1080);
    #1; chk("R2 dmiss_ready low when full", dmiss_ready, 0);
    chk("R3 imiss_ready low when full", imiss_ready, 0);
    cpl(0);
    #1; chk("R8 completion for unissued slot ignored", dmiss_ready, 0);
    co_valid = 1; co_addr = 32'h3000; @(negedge clk); co_valid = 0;
    #1; chk("R6 co_ready low after castout accepted", co_ready, 0);
    chk("R9 held request addr", bus_req_addr, 32'h1000);
    chk("R9 held request cast", bus_req_cast, 0);
    @(negedge clk);

    expect_req(32'h1000, 0, 0);
    expect_req(32'h3000, DEPTH, 1);
    expect_req(32'h1040, 1, 0);
    expect_req(32'h2000, 2, 0);
    expect_req(32'h1080, 3, 0);
    bus_req_ready = 1;
    drain();
    chk("R5 all requests seen", exp_q.size(), 0);

    cpl(2);
    #1; chk("R8 out-of-order completion reopens instr side", imiss_ready, 1);
    chk("R6 co_ready low while castout in flight", co_ready, 0);
    cpl(DEPTH);
    #1; chk("R6 co_ready high after castout completion", co_ready, 1);
    cpl(0); cpl(3); cpl(1);
    #1; chk("R8 all slots freed", dmiss_ready, 1);

    expect_req(32'h5000, 0, 0);
    expect_req(32'h5040, 1, 0);
    imiss_valid = 1; imiss_addr = 32'h5000;
    dmiss_valid = 1; dmiss_addr = 32'h5040;
    #1; chk("R10 both ready with free slots", {imiss_ready, dmiss_ready}, 2'b11);
    @(negedge clk); imiss_valid = 0; dmiss_valid = 0;
    drain();
    chk("R10 both issued", exp_q.size(), 0);
    cpl(1); cpl(0);

    bus_req_ready = 0;
    dmiss(32'h6000); dmiss(32'h6040); dmiss(32'h6080);
    imiss_valid = 1; imiss_addr = 32'h60c0;
    dmiss_valid = 1; dmiss_addr = 32'h6100;
    #1; chk("R10 instr ready with one slot", imiss_ready, 1);
    chk("R10 data refused when instr takes last slot", dmiss_ready, 0);
    @(negedge clk); imiss_valid = 0; dmiss_valid = 0;
    #1; chk("R2 full after simultaneous offer", dmiss_ready, 0);
    expect_req(32'h6000, 0, 0);
    expect_req(32'h6040, 1, 0);
    expect_req(32'h6080, 2, 0);
    expect_req(32'h60c0, 3, 0);
    @(negedge clk);
    bus_req_ready = 1;
    drain();
    chk("R5 final requests seen", exp_q.size(), 0);
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule